// File: doc/BRIEF.md
# Crypto feed DMA interrupt controller

This block is the register-mapped front end that keeps a block cipher engine supplied with data. Two memory-mover channels are programmed through it: an inbound channel that fetches cipher input from memory and an outbound channel that writes results back. Each channel has its own start address, byte count and control register. Software writes the start address, then the byte count. The count write launches the channel, which holds a transfer request toward the memory mover until a one-cycle done pulse comes back.

Completion of the two block channels, and of two further engines (hashing and public-key), is recorded in a four-bit pending vector. A mask is changed only through separate write-one-to-set and write-one-to-clear addresses. Pending bits are acknowledged by writing ones to them, and the interrupt line is the registered OR of the pending bits that are enabled. The block also returns the full/empty flags of the engines' FIFOs and holds a small FIFO routing control register that selects DES and the hash input source.

Top module: `cfeed_dma_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every register reads zero and `rx_req`, `tx_req`, `irq`, `rx_flush`, `tx_flush`, `des_sel` and `hash_src` are low. A read strobe (`bus_sel`=1, `bus_wr`=0) returns its data on `bus_rdata` in the following cycle.
- R2: Writing to offset 0x04 sets each mask bit that has a 1 in the write data. Writing to offset 0x08 clears each mask bit that has a 1. Zero bits leave the mask unchanged. Both offsets read back the mask.
- R3: Offset 0x0C reads the raw pending vector, and writing to it clears exactly the pending bits that are 1 in the data. Offset 0x00 reads pending AND mask, and writes to it are ignored.
- R4: The inbound channel is at 0x20 (start), 0x24 (count) and 0x28 (control). The outbound channel is at 0x30, 0x34 and 0x38. A count write to an idle channel with a non-zero multiple of 16 raises that channel's request on the next cycle and presents the stored start and count. The request stays high until the channel's done pulse arrives.
- R5: A count write that is zero or has any of bits 3:0 set is ignored. The channel stays idle, the count register keeps its old value and no pending bit is set.
- R6: A done pulse on a busy channel drops its request on the next cycle and sets its pending bit: inbound is bit 3, outbound is bit 2. A done pulse on an idle channel has no effect.
- R7: A `hash_done` pulse sets pending bit 1, and a `pk_done` pulse sets pending bit 0.
- R8: When a pending bit is set and cleared by a write in the same cycle, the set wins.
- R9: `irq` is a register equal to the OR over bits of pending AND mask. It changes on the same clock edge as the pending vector or mask.
- R10: Offset 0x10 returns `fifo_flags` in bits 7:0: inbound full/empty at 7/6, outbound at 5/4, hash at 3/2, public-key at 1/0.
- R11: Offset 0x14 stores bits 2:0 of the write data and reads them back. Bit 2 drives `des_sel`, and bits 1:0 drive `hash_src` (0 independent, 1 cipher input, 2 cipher output).
- R12: In a channel control register, bit 1 is stored and drives the channel's byte-swap output. Writing a 1 to bit 0 gives a single-cycle flush pulse and is not stored, so bit 0 reads 0.
- R13: While a channel is busy, writes to its start and count registers are ignored.
- R14: Reads of unmapped or unaligned offsets return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | RA_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| rx_req | output | 1 | Inbound transfer request |
| rx_addr | output | AW | Inbound start address |
| rx_len | output | LW | Inbound byte count |
| rx_swap | output | 1 | Inbound byte-swap select |
| rx_flush | output | 1 | Inbound flush pulse |
| rx_done | input | 1 | Inbound completion pulse |
| tx_req | output | 1 | Outbound transfer request |
| tx_addr | output | AW | Outbound start address |
| tx_len | output | LW | Outbound byte count |
| tx_swap | output | 1 | Outbound byte-swap select |
| tx_flush | output | 1 | Outbound flush pulse |
| tx_done | input | 1 | Outbound completion pulse |
| hash_done | input | 1 | Hash engine completion pulse |
| pk_done | input | 1 | Public-key engine completion pulse |
| fifo_flags | input | 8 | Engine FIFO full/empty flags |
| des_sel | output | 1 | DES select |
| hash_src | output | 2 | Hash input source |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a done pulse on a busy channel that lands in the same cycle as a software write acknowledging the same pending bit. The stimulus first launches the inbound channel with a legal count. It then raises `rx_done` and the pending-clear write on the same falling edge, and reads the pending vector and `irq` back afterwards. Illegal counts (zero, unaligned) and writes to a busy channel are mixed in to show that the request and the stored registers do not move.

// File: rtl/cfeed_pkg.sv
package cfeed_pkg;
  localparam int unsigned SRC_N = 4;
  localparam int unsigned SRC_PK = 0;
  localparam int unsigned SRC_HASH = 1;
  localparam int unsigned SRC_TX = 2;
  localparam int unsigned SRC_RX = 3;

  localparam logic [7:0] OFS_STAT    = 8'h00;
  localparam logic [7:0] OFS_ENSET   = 8'h04;
  localparam logic [7:0] OFS_ENCLR   = 8'h08;
  localparam logic [7:0] OFS_PEND    = 8'h0C;
  localparam logic [7:0] OFS_FIFOST  = 8'h10;
  localparam logic [7:0] OFS_FIFOCTL = 8'h14;
  localparam logic [7:0] OFS_RX_BASE = 8'h20;
  localparam logic [7:0] OFS_TX_BASE = 8'h30;
  localparam logic [7:0] OFS_START   = 8'h00;
  localparam logic [7:0] OFS_LEN     = 8'h04;
  localparam logic [7:0] OFS_CTRL    = 8'h08;

  typedef struct packed {
    logic       en_set;
    logic       en_clr;
    logic       pend_clr;
    logic       fifo_ctl;
    logic [1:0] start;
    logic [1:0] len;
    logic [1:0] ctrl;
  } wstrb_t;

  function automatic logic [7:0] chan_base(input int unsigned idx);
    return (idx == 0) ? OFS_RX_BASE : OFS_TX_BASE;
  endfunction
endpackage

// File: rtl/cfeed_decode.sv
module cfeed_decode
  import cfeed_pkg::*;
#(
  parameter int unsigned RA_W = 8
) (
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [RA_W-1:0] bus_addr,
  output wstrb_t          wstrb
);
  localparam int unsigned NCH = 2;

  always_comb begin
    wstrb = '0;
    if (bus_sel && bus_wr) begin
      wstrb.en_set   = (bus_addr == RA_W'(OFS_ENSET));
      wstrb.en_clr   = (bus_addr == RA_W'(OFS_ENCLR));
      wstrb.pend_clr = (bus_addr == RA_W'(OFS_PEND));
      wstrb.fifo_ctl = (bus_addr == RA_W'(OFS_FIFOCTL));
      for (int c = 0; c < NCH; c++) begin
        wstrb.start[c] = (bus_addr == RA_W'(chan_base(c) + OFS_START));
        wstrb.len[c]   = (bus_addr == RA_W'(chan_base(c) + OFS_LEN));
        wstrb.ctrl[c]  = (bus_addr == RA_W'(chan_base(c) + OFS_CTRL));
      end
    end
  end
endmodule

// File: rtl/cfeed_chan.sv
module cfeed_chan #(
  parameter int unsigned AW      = 32,
  parameter int unsigned LW      = 32,
  parameter int unsigned BLK_LG2 = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_start,
  input  logic          we_len,
  input  logic          we_ctrl,
  input  logic [31:0]   wdata,
  input  logic          done,
  output logic          busy,
  output logic [AW-1:0] start_q,
  output logic [LW-1:0] len_q,
  output logic          swap,
  output logic          flush,
  output logic          done_evt
);
  logic len_ok;

  // legal count: non-zero and a whole number of blocks
  assign len_ok   = (wdata[LW-1:0] != '0) && (wdata[BLK_LG2-1:0] == '0);
  assign done_evt = busy && done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      start_q <= '0;
      len_q   <= '0;
      swap    <= 1'b0;
      flush   <= 1'b0;
    end else begin
      flush <= 1'b0;
      if (!busy) begin
        if (we_start) start_q <= wdata[AW-1:0];
        if (we_len && len_ok) begin
          len_q <= wdata[LW-1:0];
          busy  <= 1'b1;
        end
      end else if (done) begin
        busy <= 1'b0;
      end
      if (we_ctrl) begin
        swap  <= wdata[1];
        flush <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/cfeed_irq.sv
module cfeed_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         en_set_we,
  input  logic         en_clr_we,
  input  logic         pend_clr_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] pend_q,
  output logic         irq
);
  logic [N-1:0] en_d, pend_d;

  always_comb begin
    en_d = en_q;
    if (en_set_we) en_d = en_d | wdata;
    if (en_clr_we) en_d = en_d & ~wdata;
    // a completion in this cycle outranks the acknowledge
    pend_d = (pend_q & ~(pend_clr_we ? wdata : '0)) | set_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      irq    <= |(pend_d & en_d);
    end
  end
endmodule

// File: rtl/cfeed_dma_ctrl.sv
module cfeed_dma_ctrl
  import cfeed_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned LW      = 32,
  parameter int unsigned BLK_LG2 = 4,
  parameter int unsigned RA_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [RA_W-1:0] bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            rx_req,
  output logic [AW-1:0]   rx_addr,
  output logic [LW-1:0]   rx_len,
  output logic            rx_swap,
  output logic            rx_flush,
  input  logic            rx_done,
  output logic            tx_req,
  output logic [AW-1:0]   tx_addr,
  output logic [LW-1:0]   tx_len,
  output logic            tx_swap,
  output logic            tx_flush,
  input  logic            tx_done,
  input  logic            hash_done,
  input  logic            pk_done,
  input  logic [7:0]      fifo_flags,
  output logic            des_sel,
  output logic [1:0]      hash_src,
  output logic            irq
);
  localparam int unsigned NCH = 2;

  wstrb_t ws;
  logic [NCH-1:0] ch_busy, ch_swap, ch_flush, ch_evt, ch_done;
  logic [AW-1:0]  ch_addr [NCH];
  logic [LW-1:0]  ch_len  [NCH];
  logic [SRC_N-1:0] set_evt, en_vec, pend_vec;
  logic [2:0]  fifo_ctl_q;
  logic [31:0] rd_mux;

  cfeed_decode #(.RA_W(RA_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wstrb   (ws)
  );

  assign ch_done = {tx_done, rx_done};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cfeed_chan #(.AW(AW), .LW(LW), .BLK_LG2(BLK_LG2)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .we_start(ws.start[c]),
      .we_len  (ws.len[c]),
      .we_ctrl (ws.ctrl[c]),
      .wdata   (bus_wdata),
      .done    (ch_done[c]),
      .busy    (ch_busy[c]),
      .start_q (ch_addr[c]),
      .len_q   (ch_len[c]),
      .swap    (ch_swap[c]),
      .flush   (ch_flush[c]),
      .done_evt(ch_evt[c])
    );
  end

  assign rx_req   = ch_busy[0];
  assign rx_addr  = ch_addr[0];
  assign rx_len   = ch_len[0];
  assign rx_swap  = ch_swap[0];
  assign rx_flush = ch_flush[0];
  assign tx_req   = ch_busy[1];
  assign tx_addr  = ch_addr[1];
  assign tx_len   = ch_len[1];
  assign tx_swap  = ch_swap[1];
  assign tx_flush = ch_flush[1];

  always_comb begin
    set_evt           = '0;
    set_evt[SRC_RX]   = ch_evt[0];
    set_evt[SRC_TX]   = ch_evt[1];
    set_evt[SRC_HASH] = hash_done;
    set_evt[SRC_PK]   = pk_done;
  end

  cfeed_irq #(.N(SRC_N)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .set_evt    (set_evt),
    .en_set_we  (ws.en_set),
    .en_clr_we  (ws.en_clr),
    .pend_clr_we(ws.pend_clr),
    .wdata      (bus_wdata[SRC_N-1:0]),
    .en_q       (en_vec),
    .pend_q     (pend_vec),
    .irq        (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)              fifo_ctl_q <= '0;
    else if (ws.fifo_ctl) fifo_ctl_q <= bus_wdata[2:0];
  end

  assign des_sel  = fifo_ctl_q[2];
  assign hash_src = fifo_ctl_q[1:0];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      RA_W'(OFS_STAT):                  rd_mux = 32'(pend_vec & en_vec);
      RA_W'(OFS_ENSET), RA_W'(OFS_ENCLR): rd_mux = 32'(en_vec);
      RA_W'(OFS_PEND):                  rd_mux = 32'(pend_vec);
      RA_W'(OFS_FIFOST):                rd_mux = 32'(fifo_flags);
      RA_W'(OFS_FIFOCTL):               rd_mux = 32'(fifo_ctl_q);
      RA_W'(OFS_RX_BASE + OFS_START):   rd_mux = 32'(ch_addr[0]);
      RA_W'(OFS_RX_BASE + OFS_LEN):     rd_mux = 32'(ch_len[0]);
      RA_W'(OFS_RX_BASE + OFS_CTRL):    rd_mux = {30'd0, ch_swap[0], 1'b0};
      RA_W'(OFS_TX_BASE + OFS_START):   rd_mux = 32'(ch_addr[1]);
      RA_W'(OFS_TX_BASE + OFS_LEN):     rd_mux = 32'(ch_len[1]);
      RA_W'(OFS_TX_BASE + OFS_CTRL):    rd_mux = {30'd0, ch_swap[1], 1'b0};
      default:                          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                    bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    else                        bus_rdata <= '0;
  end
endmodule

// File: rtl/cfeed_dma_ctrl_chk.sv
module cfeed_dma_ctrl_chk #(
  parameter int unsigned RA_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [RA_W-1:0] bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            rx_req,
  input logic            rx_done,
  input logic            rx_flush,
  input logic            tx_req,
  input logic            tx_done,
  input logic [3:0]      en,
  input logic [3:0]      pend,
  input logic            irq
);
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    rx_req && !rx_done |=> rx_req);

  assert_done_drop_R6: assert property (@(posedge clk) disable iff (rst)
    rx_req && rx_done |=> !rx_req && pend[3]);

  assert_bad_len_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_req && bus_sel && bus_wr && bus_addr == RA_W'(8'h24) &&
    (bus_wdata == 32'd0 || bus_wdata[3:0] != 4'd0) |=> !rx_req);

  assert_en_clear_R2: assert property (@(posedge clk) disable iff (rst)
    bus_sel && bus_wr && bus_addr == RA_W'(8'h08) |=> (en & $past(bus_wdata[3:0])) == 4'd0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    tx_req && tx_done |=> pend[2]);

  assert_irq_track_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend & en));

  assert_flush_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $past(bus_sel && bus_wr && bus_addr == RA_W'(8'h28) && bus_wdata[0]));
endmodule

bind cfeed_dma_ctrl cfeed_dma_ctrl_chk #(.RA_W(RA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rx_req   (rx_req),
  .rx_done  (rx_done),
  .rx_flush (rx_flush),
  .tx_req   (tx_req),
  .tx_done  (tx_done),
  .en       (en_vec),
  .pend     (pend_vec),
  .irq      (irq)
);

// File: tb/cfeed_dma_ctrl_bench.sv
module cfeed_dma_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rx_req, rx_swap, rx_flush, tx_req, tx_swap, tx_flush;
  logic [31:0] rx_addr, rx_len, tx_addr, tx_len;
  logic rx_done = 1'b0, tx_done = 1'b0, hash_done = 1'b0, pk_done = 1'b0;
  logic [7:0] fifo_flags = '0;
  logic des_sel, irq;
  logic [1:0] hash_src;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic rd_v = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  cfeed_dma_ctrl u_cfeed_dma_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_req(rx_req), .rx_addr(rx_addr), .rx_len(rx_len), .rx_swap(rx_swap),
    .rx_flush(rx_flush), .rx_done(rx_done),
    .tx_req(tx_req), .tx_addr(tx_addr), .tx_len(tx_len), .tx_swap(tx_swap),
    .tx_flush(tx_flush), .tx_done(tx_done),
    .hash_done(hash_done), .pk_done(pk_done), .fifo_flags(fifo_flags),
    .des_sel(des_sel), .hash_src(hash_src), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read-data scoreboard monitor
  always @(posedge clk) rd_v <= !rst && bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_v) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_done = 1'b1;
      1: tx_done = 1'b1;
      2: hash_done = 1'b1;
      default: pk_done = 1'b1;
    endcase
    @(negedge clk);
    rx_done = 1'b0; tx_done = 1'b0; hash_done = 1'b0; pk_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rx_req", 32'(rx_req), 0);
    check("R1 tx_req", 32'(tx_req), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 hash_src/des_sel", 32'({des_sel, hash_src}), 0);
    rd(8'h04, 0, "R1 mask");
    rd(8'h0C, 0, "R1 pending");
    rd(8'h20, 0, "R1 rx start");
    // R2 mask set/clear
    wr(8'h04, 32'hA);
    rd(8'h04, 32'hA, "R2 set read 04");
    rd(8'h08, 32'hA, "R2 set read 08");
    wr(8'h04, 32'h0);
    rd(8'h04, 32'hA, "R2 zero set");
    wr(8'h08, 32'h2);
    rd(8'h04, 32'h8, "R2 clear bit1");
    wr(8'h08, 32'h0);
    rd(8'h04, 32'h8, "R2 zero clear");
    wr(8'h08, 32'h8);
    rd(8'h04, 32'h0, "R2 clear bit3");
    // R10 fifo flags
    fifo_flags = 8'hA5;
    rd(8'h10, 32'hA5, "R10 fifo flags");
    // R11 fifo control
    wr(8'h14, 32'hFFFF_FFF6);
    check("R11 des_sel", 32'(des_sel), 1);
    check("R11 hash_src", 32'(hash_src), 2);
    rd(8'h14, 32'h6, "R11 readback");
    wr(8'h14, 32'h1);
    check("R11 hash_src cipher in", 32'({des_sel, hash_src}), 1);
    // R12 control flush and swap
    wr(8'h28, 32'h3);
    check("R12 flush pulse", 32'(rx_flush), 1);
    check("R12 swap", 32'(rx_swap), 1);
    @(negedge clk);
    check("R12 flush single cycle", 32'(rx_flush), 0);
    rd(8'h28, 32'h2, "R12 ctrl readback");
    // R5 illegal counts
    wr(8'h20, 32'h1000);
    wr(8'h24, 32'h0);
    check("R5 zero count", 32'(rx_req), 0);
    wr(8'h24, 32'h18);
    check("R5 unaligned count", 32'(rx_req), 0);
    rd(8'h24, 32'h0, "R5 count kept");
    rd(8'h0C, 32'h0, "R5 no pending");
    // R4 launch
    wr(8'h24, 32'h40);
    check("R4 rx_req", 32'(rx_req), 1);
    check("R4 rx_addr", rx_addr, 32'h1000);
    check("R4 rx_len", rx_len, 32'h40);
    rd(8'h24, 32'h40, "R4 count readback");
    // R13 writes while busy
    wr(8'h20, 32'h2000);
    wr(8'h24, 32'h80);
    check("R13 addr held", rx_addr, 32'h1000);
    check("R4 req held", 32'(rx_req), 1);
    rd(8'h20, 32'h1000, "R13 start kept");
    rd(8'h24, 32'h40, "R13 count kept");
    // R6 and R9 completion
    wr(8'h04, 32'h8);
    check("R9 irq idle", 32'(irq), 0);
    pulse(0);
    check("R6 req dropped", 32'(rx_req), 0);
    check("R9 irq raised", 32'(irq), 1);
    rd(8'h0C, 32'h8, "R6 pending bit3");
    rd(8'h00, 32'h8, "R3 status masked");
    // R3 acknowledge
    wr(8'h00, 32'h8);
    rd(8'h0C, 32'h8, "R3 status write ignored");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h8, "R3 zero ack");
    wr(8'h0C, 32'h8);
    check("R9 irq cleared", 32'(irq), 0);
    rd(8'h0C, 32'h0, "R3 ack cleared");
    // R6 done while idle
    pulse(0);
    check("R6 idle done irq", 32'(irq), 0);
    rd(8'h0C, 32'h0, "R6 idle done ignored");
    // R8 set beats clear
    wr(8'h24, 32'h10);
    check("R4 relaunch", 32'(rx_req), 1);
    @(negedge clk);
    rx_done = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h8;
    @(negedge clk);
    rx_done = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    check("R8 irq kept", 32'(irq), 1);
    rd(8'h0C, 32'h8, "R8 set wins");
    wr(8'h0C, 32'h8);
    // outbound channel
    wr(8'h30, 32'hABCD_0000);
    wr(8'h34, 32'h20);
    check("R4 tx_req", 32'(tx_req), 1);
    check("R4 tx_addr", tx_addr, 32'hABCD_0000);
    check("R4 tx_len", tx_len, 32'h20);
    wr(8'h38, 32'h2);
    check("R12 tx swap", 32'(tx_swap), 1);
    check("R12 tx no flush", 32'(tx_flush), 0);
    pulse(1);
    check("R6 tx req dropped", 32'(tx_req), 0);
    check("R9 tx masked", 32'(irq), 0);
    rd(8'h0C, 32'h4, "R6 pending bit2");
    wr(8'h04, 32'h4);
    check("R9 enable raises irq", 32'(irq), 1);
    wr(8'h0C, 32'h4);
    check("R9 ack drops irq", 32'(irq), 0);
    // R7 other sources
    pulse(2);
    pulse(3);
    rd(8'h0C, 32'h3, "R7 hash and pk pending");
    rd(8'h00, 32'h0, "R7 masked status");
    wr(8'h04, 32'h1);
    check("R7 pk irq", 32'(irq), 1);
    rd(8'h00, 32'h1, "R7 status pk");
    // R14 unmapped
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R14 unmapped 18");
    rd(8'h2C, 32'h0, "R14 unmapped 2C");
    rd(8'h22, 32'h0, "R14 unaligned 22");
    rd(8'h04, 32'hD, "R14 mask untouched");
    rd(8'h0C, 32'h3, "R14 pending untouched");
    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule